// File: doc/BRIEF.md
# Dual-Width Indirect Register Window

This block is the host-facing I/O register window of a network controller. A host issues single-cycle read or write strobes carrying a 5-bit offset, byte enables and write data. The block decodes the offset into one of five resources. These are a read-only address-PROM shadow, a shared 7-bit register pointer, a control/status data port, a bus-configuration data port and a soft-reset register. It answers with a registered acknowledge and read data one clock later.

The two data ports are indirect. Each of them reaches a bank of 128 sixteen-bit registers, and one pointer selects the entry in both banks. The window starts in a 16-bit word layout. A full four-byte write to offset 10h switches it to a 32-bit doubleword layout, and that layout then stays in force until the hardware reset input is asserted. In doubleword mode, accesses that break the width rules are acknowledged and flagged, but they have no effect.

Top module: `regwin_top`

## Requirements
- R1: After hardware reset the block is in word mode, the pointer and every bank entry read as zero, and ack_o, err_o and soft_rst_o are low.
- R2: In word mode, offsets 0h-Fh return the 16-bit PROM shadow word addr[3:1] (bytes 2k and 2k+1, little-endian) in rdata_o[15:0]. 10h is the control/status port, 12h the pointer, 14h the reset register and 16h the bus-configuration port. Data-port writes take wdata_i[15:0], and byte enables are not checked.
- R3: In doubleword mode, offsets 0h, 4h, 8h and Ch return all 32 bits of shadow dword addr[3:2] (bytes 4k to 4k+3, little-endian).
- R4: A write to offset 10h with all four byte enables set puts the block into doubleword mode from the next cycle, and it also performs the data-port write. A write to 10h with fewer byte enables leaves the block in word mode.
- R5: Only rst_n leaves doubleword mode. A reset-register read does not clear the mode.
- R6: In word mode, an access to offsets 18h-1Fh gets no acknowledge and has no effect.
- R7: The pointer keeps wdata_i[6:0] and reads back with every upper bit zero. The same pointer value indexes both banks.
- R8: In doubleword mode, an access is illegal if its offset is not a multiple of 4, if its byte enables are not 4'hF, or if it writes a non-PROM resource with nonzero wdata_i[31:16]. An illegal access gets ack_o with err_o high for that cycle and rdata_o of zero, and nothing changes.
- R9: A read of the reset register raises soft_rst_o for exactly the acknowledge cycle and returns zero.
- R10: In doubleword mode the pointer and data ports are 16 bits wide: their reads return zero in bits 31:16, and the doubleword offsets are 10h control/status, 14h pointer, 18h reset and 1Ch bus-configuration.
- R11: Every acknowledged access raises ack_o for one cycle, exactly one clock after its strobe. The acknowledge carries that access's read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset; the only way out of doubleword mode |
| addr_i | input | 5 | Byte offset from the window base |
| be_i | input | 4 | Byte enables |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | Access acknowledge, one cycle after the strobe |
| err_o | output | 1 | Illegal doubleword access flag, with ack_o |
| soft_rst_o | output | 1 | Soft-reset pulse from a reset-register read |
| dw_mode_o | output | 1 | Doubleword mode indicator |

## Verification
The properties assume that rd_i and wr_i are never high together, and that addr_i, be_i and wdata_i are stable while a strobe is high. The stimulus keeps to these rules because it issues every access from one task. That task raises a single strobe for exactly one cycle and then drops it, and only then does the next access start. The bench also never applies a strobe during reset. As a result, every acknowledge that appears can be traced to exactly one request in the cycle before it.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    parameter int unsigned OFF_W      = 5;
    parameter int unsigned BUS_W      = 32;
    parameter int unsigned DATA_W     = 16;
    parameter int unsigned BE_W       = BUS_W / 8;
    parameter int unsigned BANK_DEPTH = 128;
    parameter int unsigned NUM_BANKS  = 2;
    parameter int unsigned PROM_BYTES = 16;
    localparam int unsigned IDX_W     = $clog2(BANK_DEPTH);
    localparam int unsigned PROM_IW   = $clog2(PROM_BYTES / 2);

    localparam int unsigned BANK_CSR  = 0;
    localparam int unsigned BANK_BCR  = 1;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PROM,
        TGT_CSR,
        TGT_PTR,
        TGT_RST,
        TGT_BCR
    } tgt_e;

    typedef struct packed {
        logic             dw;
        logic [IDX_W-1:0] ptr;
        logic             ack;
        logic             err;
        logic             srst;
        logic [BUS_W-1:0] rdata;
    } regwin_state_t;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
(
    input  logic [OFF_W-1:0]   addr_i,
    input  logic [BE_W-1:0]    be_i,
    input  logic               dw_mode_i,
    output tgt_e               tgt_o,
    output logic               misfit_o,
    output logic [PROM_IW-1:0] prom_idx_o
);
    always_comb begin
        tgt_o      = TGT_NONE;
        misfit_o   = 1'b0;
        prom_idx_o = '0;
        if (dw_mode_i) begin
            misfit_o = (addr_i[1:0] != 2'b00) || (be_i != '1);
            if (!addr_i[4]) begin
                tgt_o      = TGT_PROM;
                prom_idx_o = {1'b0, addr_i[3:2]};
            end else begin
                case (addr_i[3:2])
                    2'd0:    tgt_o = TGT_CSR;
                    2'd1:    tgt_o = TGT_PTR;
                    2'd2:    tgt_o = TGT_RST;
                    default: tgt_o = TGT_BCR;
                endcase
            end
        end else begin
            if (!addr_i[4]) begin
                tgt_o      = TGT_PROM;
                prom_idx_o = addr_i[3:1];
            end else if (!addr_i[3]) begin
                case (addr_i[2:1])
                    2'd0:    tgt_o = TGT_CSR;
                    2'd1:    tgt_o = TGT_PTR;
                    2'd2:    tgt_o = TGT_RST;
                    default: tgt_o = TGT_BCR;
                endcase
            end
        end
    end
endmodule

// File: rtl/regwin_prom.sv
module regwin_prom
    import regwin_pkg::*;
#(
    parameter logic [PROM_BYTES*8-1:0] INIT = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dw_mode_i,
    input  logic [PROM_IW-1:0] idx_i,
    output logic [BUS_W-1:0]   rdata_o
);
    localparam int unsigned BYTE_IW = $clog2(PROM_BYTES);

    logic [7:0] shadow_q [PROM_BYTES];

    for (genvar b = 0; b < PROM_BYTES; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shadow_q[b] <= INIT[8*b +: 8];
            else        shadow_q[b] <= shadow_q[b];
        end
    end

    logic [BYTE_IW-1:0] base_w;
    logic [BYTE_IW-1:0] base_d;

    always_comb begin
        base_w = {idx_i, 1'b0};
        base_d = {idx_i[PROM_IW-2:0], 2'b00};
        if (dw_mode_i)
            rdata_o = {shadow_q[base_d + 3], shadow_q[base_d + 2],
                       shadow_q[base_d + 1], shadow_q[base_d]};
        else
            rdata_o = {16'h0000, shadow_q[base_w + 1], shadow_q[base_w]};
    end
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned WIDTH = 16,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IW-1:0]    idx_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/regwin_top.sv
module regwin_top
    import regwin_pkg::*;
#(
    parameter logic [PROM_BYTES*8-1:0] PROM_INIT = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              ack_o,
    output logic              err_o,
    output logic              soft_rst_o,
    output logic              dw_mode_o
);
    localparam logic [OFF_W-1:0] MODE_OFF = OFF_W'(5'h10);

    regwin_state_t st_d, st_q;

    tgt_e               tgt;
    logic               misfit;
    logic [PROM_IW-1:0] prom_idx;
    logic [BUS_W-1:0]   prom_rd;
    logic [NUM_BANKS-1:0] bank_we;
    logic [DATA_W-1:0]  bank_rd [NUM_BANKS];

    regwin_decode u_decode (
        .addr_i     (addr_i),
        .be_i       (be_i),
        .dw_mode_i  (st_q.dw),
        .tgt_o      (tgt),
        .misfit_o   (misfit),
        .prom_idx_o (prom_idx)
    );

    regwin_prom #(.INIT(PROM_INIT)) u_prom (
        .clk       (clk),
        .rst_n     (rst_n),
        .dw_mode_i (st_q.dw),
        .idx_i     (prom_idx),
        .rdata_o   (prom_rd)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        regwin_bank #(.DEPTH(BANK_DEPTH), .WIDTH(DATA_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (bank_we[g]),
            .idx_i   (st_q.ptr),
            .wdata_i (wdata_i[DATA_W-1:0]),
            .rdata_o (bank_rd[g])
        );
    end

    logic access;
    logic hi_dirty;
    logic illegal;

    always_comb begin
        access   = rd_i || wr_i;
        hi_dirty = wr_i && (tgt != TGT_PROM) && (wdata_i[BUS_W-1:DATA_W] != '0);
        illegal  = st_q.dw && (misfit || hi_dirty);

        st_d       = st_q;
        st_d.ack   = 1'b0;
        st_d.err   = 1'b0;
        st_d.srst  = 1'b0;
        st_d.rdata = '0;
        bank_we    = '0;

        if (access && (tgt != TGT_NONE)) begin
            st_d.ack = 1'b1;
            if (illegal) begin
                st_d.err = 1'b1;
            end else if (wr_i) begin
                case (tgt)
                    TGT_PTR: st_d.ptr = wdata_i[IDX_W-1:0];
                    TGT_CSR: bank_we[BANK_CSR] = 1'b1;
                    TGT_BCR: bank_we[BANK_BCR] = 1'b1;
                    default: ;
                endcase
                if ((addr_i == MODE_OFF) && (be_i == '1))
                    st_d.dw = 1'b1;
            end else begin
                case (tgt)
                    TGT_PROM: st_d.rdata = prom_rd;
                    TGT_PTR:  st_d.rdata = BUS_W'(st_q.ptr);
                    TGT_CSR:  st_d.rdata = BUS_W'(bank_rd[BANK_CSR]);
                    TGT_BCR:  st_d.rdata = BUS_W'(bank_rd[BANK_BCR]);
                    TGT_RST:  st_d.srst  = 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o    = st_q.rdata;
    assign ack_o      = st_q.ack;
    assign err_o      = st_q.err;
    assign soft_rst_o = st_q.srst;
    assign dw_mode_o  = st_q.dw;
endmodule

// File: rtl/regwin_checker.sv
module regwin_checker
    import regwin_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  addr_i,
    input logic [BE_W-1:0]   be_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [BUS_W-1:0]  rdata_o,
    input logic              ack_o,
    input logic              err_o,
    input logic              soft_rst_o,
    input logic              dw_mode_o
);
    p_ack_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(rd_i || wr_i));

    p_mode_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(dw_mode_o));

    p_mode_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 5'h10 && be_i == 4'hF) |=> dw_mode_o);

    p_no_ack_out_of_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_i || wr_i) && !dw_mode_o && addr_i[4:3] == 2'b11) |=> !ack_o);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (ack_o && dw_mode_o && rdata_o == '0));

    p_srst_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> (ack_o && !err_o && rdata_o == '0));

    p_srst_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && dw_mode_o && $past(addr_i[4])) |-> (rdata_o[31:16] == 16'h0000));
endmodule

bind regwin_top regwin_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .be_i       (be_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .rdata_o    (rdata_o),
    .ack_o      (ack_o),
    .err_o      (err_o),
    .soft_rst_o (soft_rst_o),
    .dw_mode_o  (dw_mode_o)
);

// File: tb/regwin_top_tb.sv
`timescale 1ns/1ps
module regwin_top_tb;
    localparam logic [127:0] TB_PROM = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [3:0]  be_i = '0;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        ack_o, err_o, soft_rst_o, dw_mode_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_csr [128];
    logic [15:0] exp_bcr [128];

    always #4 clk = ~clk;

    regwin_top #(.PROM_INIT(TB_PROM)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .be_i(be_i),
        .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .ack_o(ack_o), .err_o(err_o), .soft_rst_o(soft_rst_o), .dw_mode_o(dw_mode_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access: strobe for one cycle, sample the registered reply one clock later
    task automatic acc(input logic w, input logic [4:0] a, input logic [3:0] be,
                       input logic [31:0] d, output logic [31:0] rd,
                       output logic ak, output logic er, output logic sr);
        @(negedge clk);
        addr_i = a; be_i = be; wdata_i = d; rd_i = !w; wr_i = w;
        @(negedge clk);
        rd_i = 1'b0; wr_i = 1'b0;
        rd = rdata_o; ak = ack_o; er = err_o; sr = soft_rst_o;
    endtask

    function automatic logic [15:0] csr_pat(input int p);
        return 16'((p * 3 + 5) ^ 16'h1234);
    endfunction
    function automatic logic [15:0] bcr_pat(input int p);
        return 16'(p * 7 + 16'hA000);
    endfunction

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic ak, er, sr;
        for (int i = 0; i < 128; i++) begin exp_csr[i] = '0; exp_bcr[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 dw_mode", {31'b0, dw_mode_o}, 32'd0);
        chk("R1 ack/err/srst", {29'b0, ack_o, err_o, soft_rst_o}, 32'd0);
        rst_n = 1'b1;
        acc(1'b0, 5'h12, 4'h3, 0, rd, ak, er, sr);
        chk("R1 pointer zero", rd, 32'd0);
        acc(1'b0, 5'h10, 4'h3, 0, rd, ak, er, sr);
        chk("R1 bank zero", rd, 32'd0);

        // R2 word-mode PROM words
        for (int k = 0; k < 8; k++) begin
            acc(1'b0, 5'(2 * k), 4'h3, 0, rd, ak, er, sr);
            chk("R2 prom word", rd, {16'h0, TB_PROM[16*k +: 16]});
        end

        // R2/R7 fill both banks through the shared pointer
        for (int p = 0; p < 128; p++) begin
            acc(1'b1, 5'h12, 4'h3, 32'(p), rd, ak, er, sr);
            acc(1'b1, 5'h10, 4'h3, {16'h0, csr_pat(p)}, rd, ak, er, sr);
            acc(1'b1, 5'h16, 4'h3, {16'h0, bcr_pat(p)}, rd, ak, er, sr);
            exp_csr[p] = csr_pat(p);
            exp_bcr[p] = bcr_pat(p);
        end
        chk("R4 no switch on narrow writes", {31'b0, dw_mode_o}, 32'd0);
        for (int p = 0; p < 128; p++) begin
            acc(1'b1, 5'h12, 4'h1, 32'(p), rd, ak, er, sr);
            acc(1'b0, 5'h10, 4'h3, 0, rd, ak, er, sr);
            chk("R2 csr port", rd, {16'h0, exp_csr[p]});
            acc(1'b0, 5'h16, 4'h3, 0, rd, ak, er, sr);
            chk("R7 bcr port same pointer", rd, {16'h0, exp_bcr[p]});
        end

        // R7 pointer upper bits dropped
        acc(1'b1, 5'h12, 4'h3, 32'h0000FF85, rd, ak, er, sr);
        acc(1'b0, 5'h12, 4'h3, 0, rd, ak, er, sr);
        chk("R7 pointer readback", rd, 32'h5);
        acc(1'b0, 5'h10, 4'h3, 0, rd, ak, er, sr);
        chk("R7 pointer indexes low bits", rd, {16'h0, exp_csr[5]});

        // R11 ack is a single cycle
        @(negedge clk);
        chk("R11 ack single cycle", {31'b0, ack_o}, 32'd0);

        // R6 out of range in word mode
        acc(1'b1, 5'h1C, 4'h3, 32'h0000DEAD, rd, ak, er, sr);
        chk("R6 no ack on write 1C", {31'b0, ak}, 32'd0);
        acc(1'b0, 5'h18, 4'h3, 0, rd, ak, er, sr);
        chk("R6 no ack on read 18", {31'b0, ak}, 32'd0);
        acc(1'b0, 5'h1E, 4'h3, 0, rd, ak, er, sr);
        chk("R6 no ack on read 1E", {31'b0, ak}, 32'd0);
        acc(1'b0, 5'h16, 4'h3, 0, rd, ak, er, sr);
        chk("R6 bank untouched", rd, {16'h0, exp_bcr[5]});

        // R9 reset register in word mode
        acc(1'b0, 5'h14, 4'h3, 0, rd, ak, er, sr);
        chk("R9 srst pulse", {30'b0, sr, ak}, 32'h3);
        chk("R9 reads zero", rd, 32'd0);
        @(negedge clk);
        chk("R9 srst one cycle", {31'b0, soft_rst_o}, 32'd0);

        // R4 enter doubleword mode with data write at pointer 5
        acc(1'b1, 5'h10, 4'h3, 32'h00001111, rd, ak, er, sr);
        exp_csr[5] = 16'h1111;
        chk("R4 partial be stays word", {31'b0, dw_mode_o}, 32'd0);
        acc(1'b1, 5'h10, 4'hF, 32'h0000BEEF, rd, ak, er, sr);
        exp_csr[5] = 16'hBEEF;
        chk("R4 dword write enters mode", {31'b0, dw_mode_o}, 32'd1);

        // R3 full PROM dwords
        for (int k = 0; k < 4; k++) begin
            acc(1'b0, 5'(4 * k), 4'hF, 0, rd, ak, er, sr);
            chk("R3 prom dword", rd, TB_PROM[32*k +: 32]);
        end

        // R10 dword map
        acc(1'b0, 5'h14, 4'hF, 0, rd, ak, er, sr);
        chk("R10 pointer at 14", rd, 32'h5);
        acc(1'b0, 5'h10, 4'hF, 0, rd, ak, er, sr);
        chk("R10 csr at 10", rd, {16'h0, exp_csr[5]});
        acc(1'b0, 5'h1C, 4'hF, 0, rd, ak, er, sr);
        chk("R10 bcr at 1C", rd, {16'h0, exp_bcr[5]});
        acc(1'b1, 5'h14, 4'hF, 32'h00000009, rd, ak, er, sr);
        acc(1'b1, 5'h1C, 4'hF, 32'h00007777, rd, ak, er, sr);
        exp_bcr[9] = 16'h7777;
        acc(1'b0, 5'h1C, 4'hF, 0, rd, ak, er, sr);
        chk("R10 bcr write/read", rd, 32'h00007777);

        // R8 illegal accesses
        acc(1'b1, 5'h14, 4'hF, 32'h00010003, rd, ak, er, sr);
        chk("R8 dirty upper flagged", {30'b0, ak, er}, 32'h3);
        acc(1'b1, 5'h15, 4'hF, 32'h00000003, rd, ak, er, sr);
        chk("R8 misaligned write flagged", {30'b0, ak, er}, 32'h3);
        acc(1'b0, 5'h14, 4'hF, 0, rd, ak, er, sr);
        chk("R8 pointer unchanged", rd, 32'h9);
        acc(1'b1, 5'h10, 4'h3, 32'h00002222, rd, ak, er, sr);
        chk("R8 short be flagged", {30'b0, ak, er}, 32'h3);
        acc(1'b0, 5'h10, 4'hF, 0, rd, ak, er, sr);
        chk("R8 csr unchanged", rd, {16'h0, exp_csr[9]});
        acc(1'b0, 5'h12, 4'hF, 0, rd, ak, er, sr);
        chk("R8 misaligned read flag", {30'b0, ak, er}, 32'h3);
        chk("R8 misaligned read zero", rd, 32'd0);
        acc(1'b0, 5'h04, 4'h7, 0, rd, ak, er, sr);
        chk("R8 short prom read zero", rd, 32'd0);

        // R5/R9 reset register read keeps mode
        acc(1'b0, 5'h18, 4'hF, 0, rd, ak, er, sr);
        chk("R9 dword srst", {30'b0, sr, ak}, 32'h3);
        chk("R5 mode kept after soft reset", {31'b0, dw_mode_o}, 32'd1);

        // R5 hardware reset clears mode
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R5 hw reset clears mode", {31'b0, dw_mode_o}, 32'd0);
        acc(1'b0, 5'h12, 4'h3, 0, rd, ak, er, sr);
        chk("R1 pointer after reset", rd, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule